// File: doc/BRIEF.md
# Nearest-Level Staircase Command Generator

This block turns a stored mains-period sine into a level command for a battery pack whose cells can each be switched into or out of a series string. It acts once per control tick. At each tick it reads the next sample of a full 50 Hz period. There are 400 samples, one per tick at a 20 kHz tick rate. It scales the sample by an amplitude factor supplied from outside. It then divides the result by the maximum cell voltage of 4.2 V and rounds to the nearest whole number of cells. That number is the goal for the present tick.

The count actually commanded does not jump straight to the goal. It moves toward the goal by at most a programmable step per tick, so when the amplitude factor changes the staircase reaches the new shape over a few ticks. The negative half-cycle is made by reversing the polarity of the string. Polarity may only flip once the commanded count has come down to zero. A separate flag marks each tick in which the sign of the table sample changes.

A regulator outside this block supplies the amplitude factor. The signed per-tick delta tells the cell-selection logic how many cells to insert (positive) or bypass (negative).

Top module: `nl_stair_gen`

## Requirements
- R1: Reset is synchronous and active high. After reset, level_goal, level_now and level_delta are 0, neg_half is 0, zc_pulse is 0, and the next accepted tick reads table entry 0.
- R2: Table entry k (0 to 399) is 32527·sin(2πk/400) rounded to the nearest integer, with halves rounded away from zero, as a signed 16-bit code in 10 mV units. Each accepted tick consumes one entry in order, and entry 399 is followed by entry 0.
- R3: With sample s and amplitude code a (unsigned Q1.15), level_goal is floor((|s|·a + 6881280) / 13762560), capped at 128. This is the scaled magnitude divided by 420 (4.2 V), rounded half up.
- R4: An amplitude code above 32768 (1.0) gives the same result as 32768.
- R5: Each accepted tick moves level_now toward its aim by min(distance, kmax). A kmax of 0 leaves the count unchanged.
- R6: neg_half marks a negative sample. When the sample sign differs from neg_half, level_now steps toward 0 instead of toward the goal. neg_half takes the sample sign only in a tick that starts with level_now at 0, and in that same tick level_now steps toward the goal.
- R7: level_delta is the new level_now minus the previous level_now, as a 9-bit two's complement value.
- R8: zc_pulse is 1 for the interval after a tick whose sample sign bit differs from that of the previous accepted sample. After reset the previous sign counts as positive, and a zero sample counts as positive.
- R9: A tick while en is 0 changes no output and does not advance the table position.
- R10: Outputs change only on the third rising edge after the edge that samples tick high, and hold at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accept ticks when 1 |
| tick | input | 1 | One-cycle control tick strobe |
| alpha | input | 16 | Amplitude factor, unsigned Q1.15 |
| kmax | input | 4 | Largest count change allowed per tick |
| level_goal | output | 8 | Rounded level count for the latest sample |
| level_now | output | 8 | Commanded series level count after slew limiting |
| level_delta | output | 9 | Signed change of level_now in the latest tick |
| neg_half | output | 1 | Polarity of the string, 1 for negative half-cycle |
| zc_pulse | output | 1 | Sample sign changed in the latest tick |

## Verification
On every cycle the embedded properties check four things. The commanded count never moves by more than the step limit. Polarity only reverses out of a zero count. The delta agrees with the change in the count. Nothing moves between updates. The table position also stays inside the period. The bench covers what the properties cannot: the exact table values and the rounding of scaled samples across whole periods at several amplitudes, the saturation of oversized amplitude codes, slew recovery after amplitude steps, where the zero crossings fall, ticks ignored while disabled, and the exact update cycle.

// File: rtl/nlsg_pkg.sv
package nlsg_pkg;

    localparam int TBL_LEN    = 400;
    localparam int SAMP_W     = 16;
    localparam int PEAK_CODE  = 32527;
    localparam int ALPHA_W    = 16;
    localparam int ALPHA_FRAC = 15;
    localparam int CELL_CODE  = 420;
    localparam int LVL_MAX    = 128;
    localparam int KSTEP_W    = 4;

    localparam int IDX_W    = $clog2(TBL_LEN);
    localparam int LVL_W    = $clog2(LVL_MAX + 1);
    localparam int PROD_W   = SAMP_W + ALPHA_W;
    localparam int WIDE_W   = 64;
    localparam int RECIP_SH = 55;
    localparam int QUO_W    = WIDE_W - RECIP_SH;

    // divisor = cell voltage code scaled by the amplitude fraction
    localparam logic [WIDE_W-1:0] DIVISOR  = WIDE_W'(CELL_CODE) << ALPHA_FRAC;
    localparam logic [PROD_W-1:0] HALF_DIV = PROD_W'(DIVISOR >> 1);
    // ceiling reciprocal; exact for dividends below 2^31
    localparam logic [WIDE_W-1:0] RECIP =
        ((WIDE_W'(1) << RECIP_SH) + DIVISOR - WIDE_W'(1)) / DIVISOR;
    localparam logic [ALPHA_W-1:0] ALPHA_ONE = ALPHA_W'(1) << ALPHA_FRAC;
    localparam real PI_R = 3.141592653589793;

    typedef logic signed [SAMP_W-1:0] samp_t;

    typedef struct packed {
        logic              neg;
        logic [PROD_W-1:0] mag;
    } scaled_t;

    typedef struct packed {
        logic             neg;
        logic [LVL_W-1:0] goal;
    } lvl_req_t;

    typedef struct packed {
        logic             neg;
        logic [LVL_W-1:0] lvl;
    } stair_t;

    // sine code for table position k, rounded half away from zero
    function automatic samp_t sine_code(input int k);
        real v;
        v = real'(PEAK_CODE) * $sin(2.0 * PI_R * real'(k) / real'(TBL_LEN));
        if (v >= 0.0)
            return samp_t'($rtoi(v + 0.5));
        return samp_t'(-$rtoi(0.5 - v));
    endfunction

    // move 'from' toward 'to' by at most k
    function automatic logic [LVL_W-1:0] step_toward(
        input logic [LVL_W-1:0]   from,
        input logic [LVL_W-1:0]   to,
        input logic [KSTEP_W-1:0] k
    );
        logic [LVL_W-1:0] gap;
        logic [LVL_W-1:0] kk;
        logic [LVL_W-1:0] mv;
        kk  = LVL_W'(k);
        gap = (to >= from) ? (to - from) : (from - to);
        mv  = (gap > kk) ? kk : gap;
        return (to >= from) ? (from + mv) : (from - mv);
    endfunction

endpackage

// File: rtl/nlsg_phase_rom.sv
module nlsg_phase_rom
    import nlsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output logic  out_v,
    output samp_t samp
);

    samp_t            tbl [TBL_LEN];
    logic [IDX_W-1:0] idx_q;

    for (genvar i = 0; i < TBL_LEN; i++) begin : g_tbl
        assign tbl[i] = sine_code(i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            out_v <= 1'b0;
            samp  <= '0;
        end else begin
            out_v <= adv;
            if (adv) begin
                samp  <= tbl[idx_q];
                idx_q <= (idx_q == IDX_W'(TBL_LEN - 1)) ? '0 : idx_q + 1'b1;
            end
        end
    end

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        idx_q < IDX_W'(TBL_LEN));

endmodule

// File: rtl/nlsg_level_quant.sv
module nlsg_level_quant
    import nlsg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_v,
    input  samp_t              samp,
    input  logic [ALPHA_W-1:0] alpha,
    output logic               out_v,
    output lvl_req_t           req
);

    logic [ALPHA_W-1:0] a_sat;
    logic [SAMP_W-1:0]  s_mag;
    scaled_t            sc_q;
    logic               sc_v_q;

    logic [PROD_W-1:0]  num;
    logic [WIDE_W-1:0]  wide;
    logic [QUO_W-1:0]   quo;
    logic [LVL_W-1:0]   goal_c;

    // stage A: saturate amplitude, take magnitude, scale
    always_comb begin
        a_sat = (alpha > ALPHA_ONE) ? ALPHA_ONE : alpha;
        s_mag = samp[SAMP_W-1] ? SAMP_W'(-samp) : SAMP_W'(samp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_v_q <= 1'b0;
            sc_q   <= '0;
        end else begin
            sc_v_q <= in_v;
            if (in_v)
                sc_q <= '{neg: samp[SAMP_W-1],
                          mag: PROD_W'(s_mag) * PROD_W'(a_sat)};
        end
    end

    // stage B: round half up via reciprocal multiply, then cap
    always_comb begin
        num    = sc_q.mag + HALF_DIV;
        wide   = WIDE_W'(num) * RECIP;
        quo    = QUO_W'(wide >> RECIP_SH);
        goal_c = (quo > QUO_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : quo[LVL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
            req   <= '0;
        end else begin
            out_v <= sc_v_q;
            if (sc_v_q)
                req <= '{neg: sc_q.neg, goal: goal_c};
        end
    end

endmodule

// File: rtl/nlsg_slew.sv
module nlsg_slew
    import nlsg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               upd,
    input  lvl_req_t           req,
    input  logic [KSTEP_W-1:0] kmax,
    output logic [LVL_W-1:0]   goal,
    output logic [LVL_W-1:0]   lvl,
    output logic signed [LVL_W:0] delta,
    output logic               neg,
    output logic               zc
);

    stair_t                st_q;
    stair_t                st_n;
    logic signed [LVL_W:0] delta_q;
    logic [LVL_W:0]        dmag;
    logic                  zc_q;
    logic                  sign_q;
    logic [LVL_W-1:0]      goal_q;

    // polarity may only switch while the count sits at zero
    always_comb begin
        st_n = st_q;
        if (req.neg != st_q.neg) begin
            if (st_q.lvl == '0) begin
                st_n.neg = req.neg;
                st_n.lvl = step_toward('0, req.goal, kmax);
            end else begin
                st_n.lvl = step_toward(st_q.lvl, '0, kmax);
            end
        end else begin
            st_n.lvl = step_toward(st_q.lvl, req.goal, kmax);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            delta_q <= '0;
            zc_q    <= 1'b0;
            sign_q  <= 1'b0;
            goal_q  <= '0;
        end else if (upd) begin
            st_q    <= st_n;
            delta_q <= $signed({1'b0, st_n.lvl}) - $signed({1'b0, st_q.lvl});
            zc_q    <= (req.neg != sign_q);
            sign_q  <= req.neg;
            goal_q  <= req.goal;
        end
    end

    always_comb dmag = delta_q[LVL_W] ? (LVL_W+1)'(-delta_q) : (LVL_W+1)'(delta_q);

    assign goal  = goal_q;
    assign lvl   = st_q.lvl;
    assign delta = delta_q;
    assign neg   = st_q.neg;
    assign zc    = zc_q;

    assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
        upd |=> (dmag <= (LVL_W+1)'($past(kmax))));

    assert_pol_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q.neg != $past(st_q.neg)) |-> ($past(st_q.lvl) == '0));

    assert_delta_sum_R7: assert property (@(posedge clk) disable iff (rst)
        upd |=> ({1'b0, st_q.lvl} == {1'b0, $past(st_q.lvl)} + $unsigned(delta_q)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(st_q) && $stable(delta_q) && $stable(zc_q) && $stable(goal_q)));

endmodule

// File: rtl/nl_stair_gen.sv
module nl_stair_gen
    import nlsg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  tick,
    input  logic [ALPHA_W-1:0]    alpha,
    input  logic [KSTEP_W-1:0]    kmax,
    output logic [LVL_W-1:0]      level_goal,
    output logic [LVL_W-1:0]      level_now,
    output logic signed [LVL_W:0] level_delta,
    output logic                  neg_half,
    output logic                  zc_pulse
);

    logic     rom_v;
    samp_t    rom_samp;
    logic     q_v;
    lvl_req_t q_req;

    nlsg_phase_rom u_rom (
        .clk   (clk),
        .rst   (rst),
        .adv   (tick & en),
        .out_v (rom_v),
        .samp  (rom_samp)
    );

    nlsg_level_quant u_quant (
        .clk   (clk),
        .rst   (rst),
        .in_v  (rom_v),
        .samp  (rom_samp),
        .alpha (alpha),
        .out_v (q_v),
        .req   (q_req)
    );

    nlsg_slew u_slew (
        .clk   (clk),
        .rst   (rst),
        .upd   (q_v),
        .req   (q_req),
        .kmax  (kmax),
        .goal  (level_goal),
        .lvl   (level_now),
        .delta (level_delta),
        .neg   (neg_half),
        .zc    (zc_pulse)
    );

endmodule

// File: tb/nl_stair_gen_bench.sv
module nl_stair_gen_bench;

    logic              clk = 1'b0;
    logic              rst;
    logic              en;
    logic              tick;
    logic [15:0]       alpha;
    logic [3:0]        kmax;
    logic [7:0]        level_goal;
    logic [7:0]        level_now;
    logic signed [8:0] level_delta;
    logic              neg_half;
    logic              zc_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_idx, m_goal, m_lvl, m_delta;
    bit m_neg, m_sign, m_zc;

    always #2 clk = ~clk;

    nl_stair_gen u_nl_stair_gen (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .alpha(alpha), .kmax(kmax),
        .level_goal(level_goal), .level_now(level_now), .level_delta(level_delta),
        .neg_half(neg_half), .zc_pulse(zc_pulse)
    );

    function automatic int samp_of(int k);
        real v;
        v = 32527.0 * $sin(2.0 * 3.141592653589793 * real'(k) / 400.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    function automatic int goal_of(int s, int a);
        longint aa, mg, g;
        aa = (a > 32768) ? 32768 : a;
        mg = longint'((s < 0) ? -s : s) * aa;
        g  = (mg + 64'd6881280) / 64'd13762560;
        if (g > 128) g = 128;
        return int'(g);
    endfunction

    function automatic int move(int from, int to, int k);
        int gap;
        gap = (to >= from) ? to - from : from - to;
        if (gap > k) gap = k;
        return (to >= from) ? from + gap : from - gap;
    endfunction

    task automatic model_reset();
        m_idx = 0; m_goal = 0; m_lvl = 0; m_delta = 0;
        m_neg = 0; m_sign = 0; m_zc = 0;
    endtask

    task automatic model_tick();
        int s, nl;
        bit sn;
        s  = samp_of(m_idx);
        m_idx = (m_idx + 1) % 400;
        sn = (s < 0);
        m_goal = goal_of(s, int'(alpha));
        m_zc   = (sn != m_sign);
        m_sign = sn;
        if (sn != m_neg) begin
            if (m_lvl == 0) begin
                m_neg = sn;
                nl = move(0, m_goal, int'(kmax));
            end else begin
                nl = move(m_lvl, 0, int'(kmax));
            end
        end else begin
            nl = move(m_lvl, m_goal, int'(kmax));
        end
        m_delta = nl - m_lvl;
        m_lvl   = nl;
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_outs(string gtag);
        cmp(gtag, "level_goal", int'(level_goal), m_goal);
        cmp("R5", "level_now", int'(level_now), m_lvl);
        cmp("R7", "level_delta", int'(level_delta), m_delta);
        cmp("R6", "neg_half", int'(neg_half), int'(m_neg));
        cmp("R8", "zc_pulse", int'(zc_pulse), int'(m_zc));
    endtask

    task automatic tick_and_check(string gtag);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (4) @(negedge clk);
        if (en) model_tick();
        check_outs(gtag);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        cmp("R1", "level_goal", int'(level_goal), 0);
        cmp("R1", "level_now", int'(level_now), 0);
        cmp("R1", "level_delta", int'(level_delta), 0);
        cmp("R1", "neg_half", int'(neg_half), 0);
        cmp("R1", "zc_pulse", int'(zc_pulse), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b1; tick = 1'b0; alpha = 16'd32768; kmax = 4'd15;
        do_reset();

        // R10: first tick reads entry 0 (zero), second moves to level 1 on the third edge
        tick_and_check("R2");
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cmp("R10", "level_now before update", int'(level_now), 0);
        @(negedge clk);
        model_tick();
        cmp("R10", "level_now at update", int'(level_now), m_lvl);
        cmp("R10", "level_now value", int'(level_now), 1);
        repeat (2) @(negedge clk);
        check_outs("R3");

        // R3: rest of a full period at unit amplitude, wide step
        for (int i = 0; i < 398; i++) tick_and_check("R3");

        // R5: half amplitude with tight slew
        alpha = 16'd16384; kmax = 4'd2;
        for (int i = 0; i < 400; i++) tick_and_check("R3");

        // R4: amplitude code above one saturates
        alpha = 16'd65535; kmax = 4'd15;
        for (int i = 0; i < 150; i++) tick_and_check("R4");
        alpha = 16'd40000;
        for (int i = 0; i < 60; i++) tick_and_check("R4");

        // R5: amplitude steps with slow recovery
        alpha = 16'd20000; kmax = 4'd1;
        for (int i = 0; i < 100; i++) tick_and_check("R3");
        alpha = 16'd5000; kmax = 4'd3;
        for (int i = 0; i < 100; i++) tick_and_check("R3");
        alpha = 16'd32768;
        for (int i = 0; i < 30; i++) tick_and_check("R3");

        // R9: ticks while disabled are ignored
        en = 1'b0;
        for (int i = 0; i < 5; i++) tick_and_check("R9");
        en = 1'b1;
        for (int i = 0; i < 10; i++) tick_and_check("R2");

        // R5: kmax of zero freezes the count
        kmax = 4'd0;
        for (int i = 0; i < 40; i++) tick_and_check("R3");
        kmax = 4'd7;
        for (int i = 0; i < 40; i++) tick_and_check("R3");

        // R1: reset mid-run, then restart from table entry 0
        do_reset();
        alpha = 16'd24576; kmax = 4'd4;
        for (int i = 0; i < 60; i++) tick_and_check("R2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule